// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

A synchronous single-port memory whose bus never needs an idle cycle when it switches between reads and writes. Command, address and byte selects are captured on a rising edge. The data phase of that operation is the clock cycle that begins two enabled edges later. Read data is launched on that edge. Write data is captured on the edge that closes that cycle. Because both directions use the same two-cycle offset, any mix of reads and writes runs at one operation per cycle.

A load/advance control either starts a new operation or steps a 4-word burst. The burst counter only changes the two low address bits, in linear or interleaved order. An active-low clock enable freezes the whole pipeline. Three chip enables allow depth expansion. A sleep input refuses new work, and an asynchronous output enable can release the bus at any moment. The bus is split into an input word, an output word and a drive flag that stands for the tri-state enable of the pad. While the flag is low, the output word reads as zero.

Top module: `pipe_burst_sram`

## Requirements
- R1: A read started on enabled edge t puts the word on `d_out`, with `d_drive` high, from enabled edge t+2 until enabled edge t+3.
- R2: Write data on `d_in` is captured at enabled edge t+3 for a write started at edge t. Reads and writes may alternate on every cycle. A read issued one cycle after a write to the same address returns the new data.
- R3: While `clk_en_n` is high, all synchronous inputs are ignored, nothing is written, and `d_out` and `d_drive` hold their values.
- R4: A load cycle (`load_n`=0) starts an operation only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other load cycle is a deselect: it drives nothing, writes nothing and ends the burst.
- R5: An advance cycle (`load_n`=1) repeats the direction of the operation that opened the burst and ignores `rd_wr` and the chip enables. An advance with no open burst is a deselect.
- R6: With `order_il`=0, the k-th advance uses low address bits (start+k) mod 4. The upper address bits stay those of the load.
- R7: With `order_il`=1, the k-th advance uses low address bits start XOR (k mod 4).
- R8: `byte_we_n[i]`=0 on the command cycle enables byte i, which is `d_in[9i+8:9i]`. Disabled bytes keep their stored value.
- R9: `d_drive` is high only during the data phase of a read, and only while `out_en_n`=0. It drops as soon as `out_en_n` rises, without waiting for a clock edge.
- R10: A cycle with `sleep`=1 starts no operation and closes any open burst. Operations already in the pipeline still complete.
- R11: While `rst_n` is low at an edge, the pipeline empties and `d_drive` is low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low pipeline reset |
| clk_en_n | input | 1 | Active-low clock enable |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| load_n | input | 1 | 0 = load new command, 1 = advance burst |
| rd_wr | input | 1 | 1 = read, 0 = write (load cycles only) |
| byte_we_n | input | BYTES | Active-low byte write selects |
| addr | input | ADDR_W | Word address |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Refuse new operations |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| d_in | input | BYTES*BYTE_W | Write data bus |
| d_out | output | BYTES*BYTE_W | Read data bus, zero when not driven |
| d_drive | output | 1 | Bus drive enable |

## Verification
The bench goes after write-then-read of one address on neighbouring cycles. A design without the one-word forward path would return stale data there. Partial byte writes are followed at once by a read, which exposes a mask that is ignored or inverted. Long random runs mix loads, advances, deselects, sleep, clock-enable stalls and both burst orders against a reference model. A counter that wraps wrongly, uses the wrong order, or lets an advance after a deselect start a burst returns wrong data or drives the bus in a phase where it should be quiet. Stalls must freeze the outputs, and raising the output enable must drop the drive flag before any edge.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int BURST_LEN = 4;

  // low address bits for step k of a burst that started at offset st
  function automatic logic [1:0] burst_offset(input logic [1:0] st,
                                              input logic [1:0] k,
                                              input logic il);
    return il ? (st ^ k) : (st + k);
  endfunction
endpackage

// File: rtl/pbs_burst_ctl.sv
module pbs_burst_ctl import pbs_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load_n,
  input  logic              sel_ok,
  input  logic              sleep,
  input  logic              rd_wr,
  input  logic              order_il,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTES-1:0]  byte_we_n,
  output logic              op_vld,
  output logic              op_wr,
  output logic [ADDR_W-1:0] op_addr,
  output logic [BYTES-1:0]  op_be
);
  localparam int HI_W = ADDR_W - 2;

  logic            act;
  logic            b_wr;
  logic [HI_W-1:0] b_hi;
  logic [1:0]      b_st;
  logic [1:0]      b_k;
  logic [1:0]      k_nxt;

  assign k_nxt = b_k + 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act    <= 1'b0;
      op_vld <= 1'b0;
    end else if (en) begin
      if (sleep) begin
        act    <= 1'b0;
        op_vld <= 1'b0;
      end else if (!load_n) begin
        act    <= sel_ok;
        op_vld <= sel_ok;
        if (sel_ok) begin
          b_wr    <= ~rd_wr;
          b_hi    <= addr[ADDR_W-1:2];
          b_st    <= addr[1:0];
          b_k     <= 2'd0;
          op_wr   <= ~rd_wr;
          op_addr <= addr;
          op_be   <= ~byte_we_n;
        end
      end else if (act) begin
        b_k     <= k_nxt;
        op_vld  <= 1'b1;
        op_wr   <= b_wr;
        op_addr <= {b_hi, burst_offset(b_st, k_nxt, order_il)};
        op_be   <= ~byte_we_n;
      end else begin
        op_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pbs_array.sv
module pbs_array #(
  parameter int ADDR_W = 5,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    rd_vld,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    wr_vld,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTES-1:0]        wr_be,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  output logic [BYTES*BYTE_W-1:0] q,
  output logic                    drv
);
  localparam int DW    = BYTES * BYTE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] fwd;

  always_ff @(posedge clk) begin
    if (en && wr_vld) begin
      for (int i = 0; i < BYTES; i++)
        if (wr_be[i]) mem[wr_addr][i*BYTE_W +: BYTE_W] <= wdata[i*BYTE_W +: BYTE_W];
    end
  end

  // a write committing on the same edge as the read must be seen
  always_comb begin
    fwd = mem[rd_addr];
    if (wr_vld && (wr_addr == rd_addr)) begin
      for (int i = 0; i < BYTES; i++)
        if (wr_be[i]) fwd[i*BYTE_W +: BYTE_W] = wdata[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv <= 1'b0;
      q   <= '0;
    end else if (en) begin
      drv <= rd_vld;
      if (rd_vld) q <= fwd;
    end
  end
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram #(
  parameter int ADDR_W = 5,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    load_n,
  input  logic                    rd_wr,
  input  logic [BYTES-1:0]        byte_we_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    order_il,
  input  logic                    sleep,
  input  logic                    out_en_n,
  input  logic [BYTES*BYTE_W-1:0] d_in,
  output logic [BYTES*BYTE_W-1:0] d_out,
  output logic                    d_drive
);
  localparam int DW = BYTES * BYTE_W;

  logic              en;
  logic              s1_vld, s1_wr, s2_vld, s2_wr, s3_vld, s3_wr;
  logic [ADDR_W-1:0] s1_addr, s2_addr, s3_addr;
  logic [BYTES-1:0]  s1_be, s2_be, s3_be;
  logic [DW-1:0]     rd_q;
  logic              rd_drv;

  assign en = ~clk_en_n;

  pbs_burst_ctl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .en(en), .load_n(load_n),
    .sel_ok(~sel_a_n & sel_b & ~sel_c_n), .sleep(sleep), .rd_wr(rd_wr),
    .order_il(order_il), .addr(addr), .byte_we_n(byte_we_n),
    .op_vld(s1_vld), .op_wr(s1_wr), .op_addr(s1_addr), .op_be(s1_be)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_vld <= 1'b0;
      s3_vld <= 1'b0;
    end else if (en) begin
      s2_vld  <= s1_vld;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
      s3_vld  <= s2_vld;
      s3_wr   <= s2_wr;
      s3_addr <= s2_addr;
      s3_be   <= s2_be;
    end
  end

  pbs_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .en(en),
    .rd_vld(s2_vld & ~s2_wr), .rd_addr(s2_addr),
    .wr_vld(s3_vld & s3_wr), .wr_addr(s3_addr), .wr_be(s3_be),
    .wdata(d_in), .q(rd_q), .drv(rd_drv)
  );

  assign d_drive = rd_drv & ~out_en_n;
  assign d_out   = d_drive ? rd_q : '0;
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              load_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              sleep,
  input logic              out_en_n,
  input logic              d_drive,
  input logic              s1_vld,
  input logic              s1_wr,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              s2_vld,
  input logic              s2_wr,
  input logic              rd_drv
);
  p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && s2_vld && !s2_wr) |=> rd_drv);

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(s1_vld) && $stable(s2_vld) && $stable(rd_drv)));

  p_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !load_n && !(!sel_a_n && sel_b && !sel_c_n)) |=> !s1_vld);

  p_burst_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && load_n && !sleep && s1_vld) |=>
      (s1_vld && s1_wr == $past(s1_wr) &&
       s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

  p_oe_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !d_drive);

  p_sleep_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && sleep) |=> !s1_vld);
endmodule

bind pipe_burst_sram pbs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .sleep(sleep),
  .out_en_n(out_en_n), .d_drive(d_drive), .s1_vld(s1_vld), .s1_wr(s1_wr),
  .s1_addr(s1_addr), .s2_vld(s2_vld), .s2_wr(s2_wr), .rd_drv(rd_drv)
);

// File: tb/test_pipe_burst_sram.sv
module test_pipe_burst_sram;
  localparam int AW = 5, NB = 2, BW = 9, DW = NB * BW;

  logic clk = 1'b0, rst_n = 1'b0, clk_en_n = 1'b0;
  logic sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1, load_n = 1'b0, rd_wr = 1'b1;
  logic [NB-1:0] byte_we_n = '1;
  logic [AW-1:0] addr = '0;
  logic order_il = 1'b0, sleep = 1'b0, out_en_n = 1'b0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] d_out;
  logic d_drive;

  always #4 clk = ~clk;

  pipe_burst_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) i_pipe_burst_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .load_n(load_n), .rd_wr(rd_wr), .byte_we_n(byte_we_n),
    .addr(addr), .order_il(order_il), .sleep(sleep), .out_en_n(out_en_n),
    .d_in(d_in), .d_out(d_out), .d_drive(d_drive)
  );

  int checks = 0, fails = 0, n = 0;
  bit done = 1'b0;
  logic [DW-1:0] mdl [32];
  bit rv [4], rw [4];
  logic [AW-1:0] ra [4];
  logic [NB-1:0] rb [4];
  string rt [4];
  string tag_ovr = "";
  bit m_act = 0, m_wr = 0;
  logic [1:0] m_st = 0, m_k = 0;
  logic [AW-3:0] m_hi = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit cen_n, input bit ld_n, input bit sel_ok, input bit slp,
                     input bit rw_i, input logic [AW-1:0] a, input logic [NB-1:0] ben,
                     input bit oe_n);
    int s3, s2, s0;
    bit ex_drv, v, w;
    logic [DW-1:0] ex_q, wd;
    logic [AW-1:0] oa;
    string et, ot;
    logic [DW-1:0] pq;
    bit pd;
    pq = d_out; pd = d_drive;
    clk_en_n = cen_n; load_n = ld_n; sleep = slp; rd_wr = rw_i; addr = a; byte_we_n = ben;
    sel_a_n = sel_ok ? 1'b0 : 1'($urandom_range(0, 1));
    sel_c_n = sel_ok ? 1'b0 : 1'b1;
    sel_b   = sel_ok ? 1'b1 : 1'($urandom_range(0, 1));
    if (cen_n) begin
      d_in = DW'($urandom);
      @(posedge clk); #1;
      chk(d_out == pq, "R3 data hold", 32'(d_out), 32'(pq));
      chk(d_drive == pd, "R3 drive hold", 32'(d_drive), 32'(pd));
      return;
    end
    out_en_n = oe_n;
    s3 = (n + 1) & 3; s2 = (n + 2) & 3; s0 = n & 3;
    wd = DW'($urandom);
    d_in = wd;
    if (rv[s3] && rw[s3])
      for (int i = 0; i < NB; i++)
        if (rb[s3][i]) mdl[ra[s3]][i*BW +: BW] = wd[i*BW +: BW];
    ex_drv = rv[s2] && !rw[s2];
    ex_q = mdl[ra[s2]];
    et = rt[s2];
    v = 0; w = 0; oa = '0;
    if (slp) begin
      m_act = 0; ot = "R10";
    end else if (!ld_n) begin
      if (sel_ok) begin
        v = 1; w = !rw_i; oa = a; m_act = 1; m_wr = w;
        m_hi = a[AW-1:2]; m_st = a[1:0]; m_k = 0;
        ot = (tag_ovr != "") ? tag_ovr : "R1";
      end else begin
        m_act = 0; ot = "R4";
      end
    end else if (m_act) begin
      m_k = m_k + 2'd1;
      v = 1; w = m_wr;
      oa = {m_hi, order_il ? (m_st ^ m_k) : 2'((int'(m_st) + int'(m_k)) % 4)};
      ot = order_il ? "R7" : "R6";
    end else begin
      ot = "R5";
    end
    rv[s0] = v; rw[s0] = w; ra[s0] = oa; rb[s0] = ~ben; rt[s0] = ot;
    n++;
    @(posedge clk); #1;
    if (ex_drv && oe_n) et = "R9";
    chk(d_drive == (ex_drv && !oe_n), et, 32'(d_drive), 32'(ex_drv && !oe_n));
    if (ex_drv && !oe_n) begin
      chk(d_out == ex_q, et, 32'(d_out), 32'(ex_q));
      if ($urandom_range(0, 7) == 0) begin
        out_en_n = 1'b1; #1;
        chk(d_drive == 1'b0, "R9 async release", 32'(d_drive), 0);
        out_en_n = 1'b0; #1;
        chk(d_drive == 1'b1, "R9 async restore", 32'(d_drive), 1);
      end
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, 1, '0, '1, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin rv[i] = 0; rw[i] = 0; ra[i] = '0; rb[i] = '0; rt[i] = "R11"; end
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(d_drive == 1'b0, "R11 reset", 32'(d_drive), 0);
    rst_n = 1'b1;
    // preload every word with linear bursts of writes
    for (int g = 0; g < 8; g++) begin
      cyc(0, 0, 1, 0, 0, AW'(g * 4), '0, 0);
      for (int j = 0; j < 3; j++) cyc(0, 1, 0, 0, 1, '0, '0, 0);
    end
    idle(4);
    // R2: alternating directions, read right after write
    tag_ovr = "R2";
    cyc(0, 0, 1, 0, 0, 5'd3, '0, 0);
    cyc(0, 0, 1, 0, 1, 5'd3, '1, 0);
    cyc(0, 0, 1, 0, 0, 5'd9, '0, 0);
    cyc(0, 0, 1, 0, 1, 5'd9, '1, 0);
    cyc(0, 0, 1, 0, 1, 5'd3, '1, 0);
    cyc(0, 0, 1, 0, 0, 5'd3, '0, 0);
    cyc(0, 0, 1, 0, 1, 5'd3, '1, 0);
    idle(4);
    // R8: partial byte writes
    tag_ovr = "R8";
    cyc(0, 0, 1, 0, 0, 5'd17, 2'b10, 0);
    cyc(0, 0, 1, 0, 1, 5'd17, '1, 0);
    cyc(0, 0, 1, 0, 0, 5'd17, 2'b01, 0);
    cyc(0, 0, 1, 0, 1, 5'd17, '1, 0);
    cyc(0, 0, 1, 0, 0, 5'd18, 2'b11, 0);
    cyc(0, 0, 1, 0, 1, 5'd18, '1, 0);
    idle(4);
    tag_ovr = "";
    // random sweeps in both burst orders
    for (int ord = 0; ord < 2; ord++) begin
      order_il = ord[0];
      for (int i = 0; i < 6000; i++) begin
        bit cen_n, ld_n, sok, slp, oe;
        cen_n = ($urandom_range(0, 7) == 0);
        ld_n  = ($urandom_range(0, 2) != 0);
        sok   = ($urandom_range(0, 3) != 0);
        slp   = ($urandom_range(0, 15) == 0);
        oe    = ($urandom_range(0, 15) == 0);
        cyc(cen_n, ld_n, sok, slp, 1'($urandom_range(0, 1)), AW'($urandom),
            NB'($urandom), cen_n ? out_en_n : oe);
      end
      cyc(0, 0, 0, 0, 1, '0, '1, 0);
      idle(4);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule